// File: doc/BRIEF.md
# GF(64) Min-Sum Check Node

This block performs the check-node update of an extended min-sum decoder for non-binary LDPC codes with check degree four. It accepts four incoming messages, one per edge. Each message is a truncated list of NM (symbol, LLR) pairs in any order. The symbols are assumed to be already multiplied by their edge coefficients, so the parity constraint reduces to a bitwise XOR of the symbols. A smaller LLR marks a more reliable symbol.

For every edge the block builds a full outgoing vector of Q = 2^SW LLR entries from the three other messages. Entry s holds the smallest LLR sum over all combinations of one entry from each of those three lists whose symbols XOR to s. Every entry of every list takes part, so the search spans NM^3 combinations per edge, and the inputs need no sorting. The work is done by one two-input elementary combiner that handles one candidate per clock. It runs a fixed forward/backward schedule of six passes and keeps the partial results as full Q-entry vectors, so no intermediate truncation takes place. Symbols that no combination reaches are reported at the saturated maximum LLR.

The input is a single valid/ready beat that carries all four lists. `in_ready` is high only while the block is idle, and a beat is taken on a clock edge where both `in_valid` and `in_ready` are high. When the computation finishes, `done` pulses for one cycle. The results then stream out as 4*Q valid/ready beats. While `out_valid` is high and `out_ready` is low, the current beat holds. A beat advances only on a clock edge where both are high.

Top module: `gf_check_node`

## Requirements
- R1: Outgoing entry (e, s) equals the minimum, over every combination of one entry from each list other than list e, of the saturated sum of their LLRs, restricted to combinations whose symbol XOR equals s. Duplicate symbols within a list are allowed.
- R2: The output index of a combination is the bitwise XOR of the SW-bit symbols chosen from the three other lists.
- R3: An outgoing entry that no combination reaches reads as all ones (2^LW - 1).
- R4: LLR sums saturate at 2^LW - 1 and never wrap.
- R5: Outgoing vector e does not depend on list e: changing only list e leaves every entry of vector e unchanged.
- R6: The order of entries within an input list has no effect on any output.
- R7: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` is 0 from the accepting edge until the last output beat is taken, and it returns to 1 on the following cycle.
- R8: `done` is high for exactly one cycle, 6 + 2*NM*NM + 4*Q*NM clock edges after the accepting edge, in the same cycle that `out_valid` first rises.
- R9: Output beats run edge-major: `out_edge` runs 0 to 3 and, within each edge, `out_sym` runs 0 to Q-1. `out_last` marks edge 3, symbol Q-1. A beat held under back-pressure keeps `out_edge`, `out_sym` and `out_llr` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block idle and able to take a beat |
| in_sym | input | 4*NM*SW | Symbols; entry k of list e at bits [(e*NM+k)*SW +: SW] |
| in_llr | input | 4*NM*LW | LLRs; entry k of list e at bits [(e*NM+k)*LW +: LW] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the current output beat |
| out_edge | output | 2 | Edge of the current output beat |
| out_sym | output | SW | Symbol index of the current output beat |
| out_llr | output | LW | Outgoing LLR for (out_edge, out_sym) |
| out_last | output | 1 | Final beat of the result |
| done | output | 1 | One-cycle pulse when the results become available |

## Verification
The bench uses the default build: NM = 8, SW = 6, LW = 8. With these values a brute-force reference over all 512 combinations per edge is cheap enough to recompute for each input set. An 8-bit LLR lets three large inputs overflow their sum, which makes saturation reachable. Lists whose symbols are restricted to two values leave 62 of the 64 outputs per edge unreachable. The cases that show edge exclusion and order independence compare the streamed vectors across runs that differ only in one list or only in entry order. Random back-pressure on the output exercises the hold rule.

// File: rtl/gfcn_pkg.sv
package gfcn_pkg;
  localparam int DC   = 4;  // check degree, fixed by the schedule below
  localparam int NOPS = 6;  // elementary passes per update
  localparam int NBUF = 6;  // vector buffers: 0 fwd, 1 bwd, 2..5 outgoing

  typedef enum logic [1:0] {ST_IDLE, ST_CLR, ST_RUN, ST_OUT} st_e;

  // one pass: A operand (a list or a stored vector) combined with list b_list into dst
  typedef struct packed {
    logic       a_vec;
    logic [1:0] a_src;
    logic [1:0] b_list;
    logic [2:0] dst;
  } op_t;

  function automatic op_t op_lookup(input logic [2:0] k);
    op_t o;
    case (k)
      3'd0:    o = '{a_vec: 1'b0, a_src: 2'd0, b_list: 2'd1, dst: 3'd0}; // fwd = m0 (+) m1
      3'd1:    o = '{a_vec: 1'b1, a_src: 2'd0, b_list: 2'd2, dst: 3'd5}; // out3 = fwd (+) m2
      3'd2:    o = '{a_vec: 1'b0, a_src: 2'd3, b_list: 2'd2, dst: 3'd1}; // bwd = m3 (+) m2
      3'd3:    o = '{a_vec: 1'b1, a_src: 2'd1, b_list: 2'd1, dst: 3'd2}; // out0 = bwd (+) m1
      3'd4:    o = '{a_vec: 1'b1, a_src: 2'd1, b_list: 2'd0, dst: 3'd3}; // out1 = bwd (+) m0
      default: o = '{a_vec: 1'b1, a_src: 2'd0, b_list: 2'd3, dst: 3'd4}; // out2 = fwd (+) m3
    endcase
    return o;
  endfunction
endpackage

// File: rtl/gfcn_elem.sv
module gfcn_elem #(
  parameter int SW = 6,
  parameter int LW = 8
) (
  input  logic [SW-1:0] a_sym,
  input  logic [LW-1:0] a_llr,
  input  logic [SW-1:0] b_sym,
  input  logic [LW-1:0] b_llr,
  input  logic [LW-1:0] cur_llr,
  output logic [SW-1:0] idx,
  output logic [LW-1:0] sum,
  output logic          upd
);
  logic [LW:0] raw;

  always_comb begin
    raw = {1'b0, a_llr} + {1'b0, b_llr};
    sum = raw[LW] ? '1 : raw[LW-1:0];
    idx = a_sym ^ b_sym;
    upd = (sum < cur_llr);
  end
endmodule

// File: rtl/gfcn_sched.sv
module gfcn_sched
  import gfcn_pkg::*;
#(
  parameter int NM  = 8,
  parameter int SW  = 6,
  parameter int NMW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           out_ready,
  output logic           in_ready,
  output logic           clr,
  output logic           run,
  output logic           done,
  output logic           out_valid,
  output logic           out_last,
  output op_t            op,
  output logic [SW-1:0]  i_idx,
  output logic [NMW-1:0] j_idx,
  output logic [1:0]     out_edge,
  output logic [SW-1:0]  out_sym
);
  st_e            st;
  logic [2:0]     opk;
  logic [SW-1:0]  i_q;
  logic [NMW-1:0] j_q;
  logic [1:0]     edge_q;
  logic [SW-1:0]  sym_q;
  logic           done_q;
  logic           j_last, i_last, fin;

  always_comb begin
    op       = op_lookup(opk);
    j_last   = (j_q == NMW'(NM - 1));
    i_last   = op.a_vec ? (i_q == '1) : (i_q == SW'(NM - 1));
    fin      = (st == ST_RUN) && j_last && i_last && (opk == 3'(NOPS - 1));
    in_ready = (st == ST_IDLE);
    clr      = (st == ST_CLR);
    run      = (st == ST_RUN);
    out_valid = (st == ST_OUT);
    out_last = (edge_q == 2'd3) && (sym_q == '1);
    done     = done_q;
    i_idx    = i_q;
    j_idx    = j_q;
    out_edge = edge_q;
    out_sym  = sym_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      opk    <= '0;
      i_q    <= '0;
      j_q    <= '0;
      edge_q <= '0;
      sym_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      case (st)
        ST_IDLE: if (in_valid) begin
          st  <= ST_CLR;
          opk <= '0;
        end
        ST_CLR: begin
          st  <= ST_RUN;
          i_q <= '0;
          j_q <= '0;
        end
        ST_RUN: begin
          if (j_last) begin
            j_q <= '0;
            if (i_last) begin
              if (opk == 3'(NOPS - 1)) begin
                st     <= ST_OUT;
                edge_q <= '0;
                sym_q  <= '0;
              end else begin
                opk <= opk + 3'd1;
                st  <= ST_CLR;
              end
            end else begin
              i_q <= i_q + 1'b1;
            end
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        default: if (out_ready) begin
          if (out_last) begin
            st <= ST_IDLE;
          end else begin
            sym_q <= sym_q + 1'b1;
            if (sym_q == '1) edge_q <= edge_q + 2'd1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gf_check_node.sv
module gf_check_node
  import gfcn_pkg::*;
#(
  parameter int NM = 8,   // entries per truncated list, a power of two >= 2
  parameter int SW = 6,   // symbol width, Q = 2**SW
  parameter int LW = 8    // LLR width
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DC*NM*SW-1:0] in_sym,
  input  logic [DC*NM*LW-1:0] in_llr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_edge,
  output logic [SW-1:0]      out_sym,
  output logic [LW-1:0]      out_llr,
  output logic               out_last,
  output logic               done
);
  localparam int Q   = 1 << SW;
  localparam int NMW = $clog2(NM);
  localparam int LSZ = DC * NM;
  localparam int LIW = 2 + NMW;

  logic [SW-1:0] lsym [LSZ];
  logic [LW-1:0] lllr [LSZ];
  logic [LW-1:0] vmem [NBUF][Q];

  op_t            op;
  logic           clr, run;
  logic [SW-1:0]  i_idx;
  logic [NMW-1:0] j_idx;
  logic [LIW-1:0] a_li, b_li;
  logic [SW-1:0]  a_sym, b_sym, idx;
  logic [LW-1:0]  a_llr, b_llr, cur_llr, sum;
  logic           upd;

  gfcn_sched #(.NM(NM), .SW(SW), .NMW(NMW)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .clr(clr), .run(run), .done(done),
    .out_valid(out_valid), .out_last(out_last), .op(op),
    .i_idx(i_idx), .j_idx(j_idx), .out_edge(out_edge), .out_sym(out_sym)
  );

  // operand selection: A walks a list (NM entries) or a stored vector (Q entries)
  always_comb begin
    a_li    = {op.a_src, i_idx[NMW-1:0]};
    b_li    = {op.b_list, j_idx};
    a_sym   = op.a_vec ? i_idx : lsym[a_li];
    a_llr   = op.a_vec ? vmem[{1'b0, op.a_src}][i_idx] : lllr[a_li];
    b_sym   = lsym[b_li];
    b_llr   = lllr[b_li];
    cur_llr = vmem[op.dst][idx];
    out_llr = vmem[{1'b0, out_edge} + 3'd2][out_sym];
  end

  gfcn_elem #(.SW(SW), .LW(LW)) u_elem (
    .a_sym(a_sym), .a_llr(a_llr), .b_sym(b_sym), .b_llr(b_llr),
    .cur_llr(cur_llr), .idx(idx), .sum(sum), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      for (int k = 0; k < LSZ; k++) begin
        lsym[k] <= in_sym[k*SW +: SW];
        lllr[k] <= in_llr[k*LW +: LW];
      end
    end
    if (clr) begin
      for (int s = 0; s < Q; s++) vmem[op.dst][s] <= '1;
    end else if (run && upd) begin
      vmem[op.dst][idx] <= sum;
    end
  end
endmodule

// File: rtl/gfcn_chk.sv
module gfcn_chk #(
  parameter int SW = 6,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_edge,
  input logic [SW-1:0] out_sym,
  input logic [LW-1:0] out_llr,
  input logic          out_last,
  input logic          done
);
  assert_busy_no_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_edge) && $stable(out_sym) && $stable(out_llr)));

  assert_last_position_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_edge == 2'd3 && out_sym == '1));
endmodule

bind gf_check_node gfcn_chk #(.SW(SW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_edge(out_edge), .out_sym(out_sym),
  .out_llr(out_llr), .out_last(out_last), .done(done)
);

// File: tb/gf_check_node_bench.sv
module gf_check_node_bench;
  localparam int NM   = 8;
  localparam int SW   = 6;
  localparam int LW   = 8;
  localparam int DC   = 4;
  localparam int Q    = 1 << SW;
  localparam int MAXV = (1 << LW) - 1;
  localparam int LAT  = 6 + 2*NM*NM + 4*Q*NM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_last, done;
  logic [DC*NM*SW-1:0] in_sym = '0;
  logic [DC*NM*LW-1:0] in_llr = '0;
  logic [1:0]    out_edge;
  logic [SW-1:0] out_sym;
  logic [LW-1:0] out_llr;

  int n_run = 0;
  int n_bad = 0;
  int bsym [DC][NM];
  int bllr [DC][NM];
  int ssym [DC][NM];
  int sllr [DC][NM];
  int expv [DC][Q];
  int got  [DC][Q];
  int ref_a [DC][Q];

  always #5 clk = ~clk;

  gf_check_node #(.NM(NM), .SW(SW), .LW(LW)) u_gf_check_node (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .in_llr(in_llr), .out_valid(out_valid), .out_ready(out_ready),
    .out_edge(out_edge), .out_sym(out_sym), .out_llr(out_llr),
    .out_last(out_last), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // brute-force reference: R1 minimum over all combinations, R2 XOR index, R4 saturation
  task automatic model();
    for (int e = 0; e < DC; e++) begin
      int oth [3];
      int n = 0;
      for (int m = 0; m < DC; m++) if (m != e) begin oth[n] = m; n++; end
      for (int s = 0; s < Q; s++) expv[e][s] = MAXV;
      for (int x = 0; x < NM; x++)
        for (int y = 0; y < NM; y++)
          for (int z = 0; z < NM; z++) begin
            int sy = bsym[oth[0]][x] ^ bsym[oth[1]][y] ^ bsym[oth[2]][z];
            int su = bllr[oth[0]][x] + bllr[oth[1]][y] + bllr[oth[2]][z];
            if (su > MAXV) su = MAXV;
            if (su < expv[e][sy]) expv[e][sy] = su;
          end
    end
  endtask

  task automatic fill(input int smax, input int lmin, input int lmax);
    for (int e = 0; e < DC; e++)
      for (int k = 0; k < NM; k++) begin
        bsym[e][k] = $urandom_range(smax, 0);
        bllr[e][k] = $urandom_range(lmax, lmin);
      end
  endtask

  task automatic run(input string sat_tag);
    int cnt = 0;
    int beat = 0;
    int it = 0;
    model();
    for (int e = 0; e < DC; e++)
      for (int k = 0; k < NM; k++) begin
        in_sym[(e*NM+k)*SW +: SW] = SW'(bsym[e][k]);
        in_llr[(e*NM+k)*LW +: LW] = LW'(bllr[e][k]);
      end
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready before accept", int'(in_ready), 1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R7 busy after accept", int'(in_ready), 0);
    while (!done && cnt < LAT + 20) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == LAT, "R8 done latency", cnt, LAT);
    chk(out_valid == 1'b1, "R8 out_valid with done", int'(out_valid), 1);
    while (beat < DC*Q) begin
      int e = beat / Q;
      int s = beat % Q;
      if (it == 1) chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
      chk(out_valid && out_edge == 2'(e) && out_sym == SW'(s), "R9 beat order",
          int'(out_edge) * Q + int'(out_sym), beat);
      chk(out_last == (beat == DC*Q - 1), "R9 last flag", int'(out_last), int'(beat == DC*Q - 1));
      chk(int'(out_llr) == expv[e][s], (expv[e][s] == MAXV) ? sat_tag : "R1 R2 min sum",
          int'(out_llr), expv[e][s]);
      got[e][s] = int'(out_llr);
      out_ready = ($urandom_range(3, 0) != 0);
      if (out_ready) beat++;
      it++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R7 idle after last beat", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 || in_ready == 1'b1, "R7 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R8 reset done", int'(done), 0);

    // random symbols, small LLRs: R1 and R2
    fill(Q - 1, 0, 30);
    ssym = bsym; sllr = bllr;
    run("R3 unreached");
    ref_a = got;

    // R5: only list 0 changes, vector 0 must match the earlier run
    for (int k = 0; k < NM; k++) begin
      bsym[0][k] = $urandom_range(Q - 1, 0);
      bllr[0][k] = $urandom_range(30, 0);
    end
    run("R3 unreached");
    for (int s = 0; s < Q; s++)
      chk(got[0][s] == ref_a[0][s], "R5 own edge excluded", got[0][s], ref_a[0][s]);

    // R6: same lists as the first run, entries reversed
    for (int e = 0; e < DC; e++)
      for (int k = 0; k < NM; k++) begin
        bsym[e][k] = ssym[e][NM - 1 - k];
        bllr[e][k] = sllr[e][NM - 1 - k];
      end
    run("R3 unreached");
    for (int e = 0; e < DC; e++)
      for (int s = 0; s < Q; s++)
        chk(got[e][s] == ref_a[e][s], "R6 order independent", got[e][s], ref_a[e][s]);

    // R3: symbols from {0,1} only leave most outputs unreached
    fill(1, 0, 60);
    run("R3 unreached");

    // R4: large LLRs overflow the sum and must saturate
    fill(Q - 1, 90, MAXV);
    run("R4 saturation");

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule